// File: doc/BRIEF.md
# I2C Target Front End

This block is the bus-facing half of a small converter peripheral. It listens to the two open-drain lines of an I2C/SMBus bus (7-bit addressing), which it samples with a faster system clock. It recognises START, repeated START and STOP. It takes in the target address one bit at a time and checks each bit as it arrives. It acknowledges its own address by pulling SDA low. It gathers the written bytes into a register-block word and, for reads, shifts out a word supplied by the register block. The register block sees only three things: a word, a one-cycle commit strobe, and a readback word input.

The address is seven bits. The upper six come from a parameter and the lowest comes from an address-select pin. Once the block sees a wrong address bit, or a STOP, it stops reacting to SCL until the next START. A STOP that comes in the same SCL-high phase as its START is not honoured. A written word is handed over only when SCL falls at the end of the acknowledge clock of the word's final byte.

The controller has these states. IDLE is gated and ignores SCL. ADDR shifts in the address and R/W bit. ADDR_ACK pulls SDA for the address acknowledge. WR_BYTE shifts in a data byte. WR_ACK pulls SDA for the data acknowledge. RD_BYTE drives a byte out. RD_ACK releases SDA while the controller acknowledges.

Transitions:
- Any state goes to ADDR on START.
- Any state goes to IDLE on an honoured STOP.
- ADDR goes to IDLE on a mismatching address bit, or on an all-zero address.
- ADDR goes to ADDR_ACK on the SCL fall after the R/W bit.
- ADDR_ACK goes to WR_BYTE (R/W = 0) or RD_BYTE (R/W = 1) on the SCL fall.
- WR_BYTE goes to WR_ACK after eight bits.
- WR_ACK goes to WR_BYTE on the SCL fall.
- RD_BYTE goes to RD_ACK after eight bits.
- RD_ACK goes to RD_BYTE on a controller ACK for a byte that is not the last.
- RD_ACK goes to IDLE on NACK or after the last byte.

Top module: `twi_target_fe`

## Requirements
- R1: After reset the block releases SDA (`sda_pull_o` = 0) and does not raise `wr_commit_o`.
- R2: SDA falling while SCL is high (START) always begins a new address phase. This holds from idle and also in the middle of a transfer (repeated START), so a write can be followed by a repeated START and a read.
- R3: The address byte is seven address bits, MSB first, then R/W (0 = write, 1 = read). The expected address is `{OWN_HI, adr_sel_i}`. On a match the block holds `sda_pull_o` = 1 throughout the ninth SCL high phase.
- R4: At the first address bit that differs from the expected address, the block stops driving and stays ignored until the next START. It does not acknowledge any later bits, even ones that spell its own address.
- R5: SDA rising while SCL is high (STOP) sends the block to IDLE. After that it acknowledges nothing until a START.
- R6: A STOP in the same SCL high phase as the START that began the transfer is disregarded, and the address phase continues.
- R7: An address byte whose seven address bits are all zero (general call) is never acknowledged.
- R8: Every written byte is acknowledged. Each group of `WORD_BYTES` bytes forms one word, with the first byte in the most significant position. `wr_word_o` is loaded and `wr_commit_o` pulses for one clock right after SCL falls at the end of the acknowledge clock of the group's last byte. Back-to-back bytes in one transfer form successive words.
- R9: A write cut short by START or STOP before that falling edge commits nothing. The next frame starts again at the first byte.
- R10: In a read, `rd_word_i` is captured when the address acknowledge begins. It is sent most significant byte first, MSB first. A data bit of 0 is sent as `sda_pull_o` = 1. SDA is released during the controller's acknowledge clock.
- R11: A read ends after the last byte of the word, or after a controller NACK (SDA high in the acknowledge clock). After that the block drives nothing until a START.
- R12: `sda_pull_o` only pulls low or releases, and it never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| adr_sel_i | input | 1 | Lowest address bit |
| rd_word_i | input | 8*WORD_BYTES | Word returned on reads |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_word_o | output | 8*WORD_BYTES | Last committed write word |
| wr_commit_o | output | 1 | One-cycle strobe when `wr_word_o` is updated |

## Verification
A wrong controller state shows up on the bus within one SCL period. It appears as an acknowledge pulled or missed in the ninth clock of the address or data byte, or as a read bit that is driven when it should be released. A lost byte index or a bad commit state shows up on the very next frame, as a strobe outside the final acknowledge clock or as a word with swapped bytes. The bench compares SDA on every clock of each SCL high phase, and checks every strobe against a queue of expected words.

// File: rtl/twi_fe_pkg.sv
package twi_fe_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } fe_state_t;
endpackage

// File: rtl/twi_line_sync.sv
// Synchronises one bus line into the system clock and flags its edges.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl_o  = chain[STAGES-1];
    assign rise_o = lvl_o & ~prev;
    assign fall_o = ~lvl_o & prev;
endmodule

// File: rtl/twi_bus_cond.sv
// START / STOP recognition; a STOP inside the START's own SCL-high phase is dropped.
module twi_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic scl_fall,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    logic fresh;   // still inside the SCL-high phase of the last START

    assign start_o = scl_lvl & sda_fall;
    assign stop_o  = scl_lvl & sda_rise & ~fresh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fresh <= 1'b0;
        else if (start_o)  fresh <= 1'b1;
        else if (scl_fall) fresh <= 1'b0;
    end
endmodule

// File: rtl/twi_target_fe.sv
module twi_target_fe
    import twi_fe_pkg::*;
#(
    parameter logic [5:0] OWN_HI      = 6'b011010,
    parameter int         WORD_BYTES  = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    input  logic                         adr_sel_i,
    input  logic [WORD_BYTES*BYTE_W-1:0] rd_word_i,
    output logic                         sda_pull_o,
    output logic [WORD_BYTES*BYTE_W-1:0] wr_word_o,
    output logic                         wr_commit_o
);
    localparam int WORD_W = WORD_BYTES * BYTE_W;
    localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam int CNT_W  = 4;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_ev, stop_ev;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );
    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );
    twi_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
        .sda_rise(sda_rise), .sda_fall(sda_fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    fe_state_t          state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  rx_sh;
    logic [WORD_W-1:0]  tx_sh;
    logic [WORD_W-1:0]  hold;
    logic [IDX_W-1:0]   bidx;
    logic               rw;
    logic [BYTE_W-1:0]  own_addr;
    logic               addr_miss, gc_hit, last_b;

    // Padded so that bit index 7-cnt selects A6 for cnt=0 down to A0 for cnt=6.
    assign own_addr  = {OWN_HI, adr_sel_i, 1'b0};
    assign addr_miss = (cnt < 4'd7) && (sda_lvl != own_addr[3'd7 - cnt[2:0]]);
    assign gc_hit    = (cnt == 4'd7) && (rx_sh[ADDR_W-1:0] == '0);
    assign last_b    = (bidx == IDX_W'(WORD_BYTES - 1));

    // Next-state logic
    always_comb begin
        nxt = state;
        if (start_ev) begin
            nxt = ST_ADDR;
        end else if (stop_ev) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR: begin
                    if (scl_rise && (addr_miss || gc_hit))  nxt = ST_IDLE;
                    else if (scl_fall && cnt == 4'd8)       nxt = ST_ADDR_ACK;
                end
                ST_ADDR_ACK: if (scl_fall) nxt = rw ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && cnt == 4'd8) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && cnt == 4'd8) nxt = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (scl_rise && (sda_lvl || last_b)) nxt = ST_IDLE;
                    else if (scl_fall)                   nxt = ST_RD_BYTE;
                end
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            hold        <= '0;
            bidx        <= '0;
            rw          <= 1'b0;
            sda_pull_o  <= 1'b0;
            wr_word_o   <= '0;
            wr_commit_o <= 1'b0;
        end else begin
            wr_commit_o <= 1'b0;
            if (start_ev) begin
                cnt        <= '0;
                bidx       <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop_ev) begin
                sda_pull_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
                            cnt   <= cnt + 4'd1;
                            if (cnt == 4'd7) rw <= sda_lvl;
                        end else if (scl_fall && cnt == 4'd8) begin
                            sda_pull_o <= 1'b1;
                            cnt        <= '0;
                            bidx       <= '0;
                            tx_sh      <= rd_word_i;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                sda_pull_o <= ~tx_sh[WORD_W-1];
                                tx_sh      <= tx_sh << 1;
                                cnt        <= 4'd1;
                            end else begin
                                sda_pull_o <= 1'b0;
                                cnt        <= '0;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            sda_pull_o <= 1'b1;
                            hold       <= (hold << BYTE_W) | WORD_W'(rx_sh);
                            cnt        <= '0;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_pull_o <= 1'b0;
                            if (last_b) begin
                                wr_word_o   <= hold;
                                wr_commit_o <= 1'b1;
                                bidx        <= '0;
                            end else begin
                                bidx <= bidx + IDX_W'(1);
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_pull_o <= 1'b0;
                            end else begin
                                sda_pull_o <= ~tx_sh[WORD_W-1];
                                tx_sh      <= tx_sh << 1;
                                cnt        <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_fall) begin
                            sda_pull_o <= ~tx_sh[WORD_W-1];
                            tx_sh      <= tx_sh << 1;
                            cnt        <= 4'd1;
                            bidx       <= bidx + IDX_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Acknowledge clocks hold SDA low
    assert_ack_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK || state == ST_WR_ACK) |-> sda_pull_o);

    // Gated state never drives the bus
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o);

    // An honoured STOP always parks the controller
    assert_stop_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE));

    // Commit strobe only follows an SCL falling edge
    assert_commit_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(scl_fall));

    // Controller acknowledge clock of a read: SDA released
    assert_rd_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK) |-> !sda_pull_o);

    // No SDA change while SCL stays high
    assert_pull_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull_o));
endmodule

// File: tb/twi_target_fe_tb_top.sv
`timescale 1ns/1ps
module twi_target_fe_tb_top;
    localparam int Q = 8;   // system clocks per bus quarter

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        adr_sel = 1'b1;
    logic [15:0] rd_word = 16'h0000;
    logic        sda_pull;
    logic [15:0] wr_word;
    logic        wr_commit;
    logic        sda_bus;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_bus = sda_m & ~sda_pull;

    twi_target_fe #(.OWN_HI(6'b011010), .WORD_BYTES(2), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .adr_sel_i(adr_sel), .rd_word_i(rd_word),
        .sda_pull_o(sda_pull), .wr_word_o(wr_word), .wr_commit_o(wr_commit)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic        chk_en = 1'b0;
    logic        exp_pull = 1'b0;
    logic        win = 1'b0;
    logic        done = 1'b0;
    string       cur_req = "R1";
    logic [15:0] exp_q[$];
    logic [15:0] exp_w;

    // Per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (chk_en) begin
            n_cmp++;
            if (sda_pull !== exp_pull) begin
                n_bad++;
                $display("FAIL %s: sda_pull=%0b expected %0b at %0t", cur_req, sda_pull, exp_pull, $time);
            end
        end
        if (wr_commit === 1'b1) begin
            n_cmp++;
            if (!win || exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R9: commit of %h, expected no commit at %0t", wr_word, $time);
            end else begin
                exp_w = exp_q.pop_front();
                if (wr_word !== exp_w) begin
                    n_bad++;
                    $display("FAIL R8: word %h expected %h", wr_word, exp_w);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SCL pulse; entered with SCL low
    task automatic bit_cyc(input logic b, input logic ep);
        sda_m = b;
        tick(Q);
        exp_pull = ep;
        scl_m = 1'b1;
        tick(4);
        chk_en = 1'b1;
        tick(Q - 4);
        chk_en = 1'b0;
        scl_m = 1'b0;
        tick(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack, input logic commit_ok);
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], 1'b0);
        win = commit_ok;
        bit_cyc(1'b1, ack);
        tick(4);
        win = 1'b0;
    endtask

    task automatic rd_byte(input logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) bit_cyc(1'b1, ~v[i]);
        bit_cyc(~mack, 1'b0);
    endtask

    task automatic quiet_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], 1'b0);
        bit_cyc(1'b1, 1'b0);
    endtask

    initial begin
        tick(5);
        n_cmp++;
        if (sda_pull !== 1'b0 || wr_commit !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: pull=%0b commit=%0b expected 0 0", sda_pull, wr_commit);
        end
        rst_n = 1'b1;
        tick(5);
        n_cmp++;
        if (sda_pull !== 1'b0 || wr_commit !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: after release pull=%0b commit=%0b expected 0 0", sda_pull, wr_commit);
        end

        // R3 R8: plain two-byte write
        bus_start();
        cur_req = "R3"; send_byte(8'h6A, 1'b1, 1'b0);
        cur_req = "R8"; send_byte(8'hC3, 1'b1, 1'b0);
        exp_q.push_back(16'hC35A);
        send_byte(8'h5A, 1'b1, 1'b1);
        bus_stop();

        // R8: back-to-back words in one transfer
        bus_start();
        cur_req = "R8"; send_byte(8'h6A, 1'b1, 1'b0);
        send_byte(8'h12, 1'b1, 1'b0);
        exp_q.push_back(16'h1234);
        send_byte(8'h34, 1'b1, 1'b1);
        send_byte(8'hAB, 1'b1, 1'b0);
        exp_q.push_back(16'hABCD);
        send_byte(8'hCD, 1'b1, 1'b1);
        bus_stop();

        // R9: writes cut short by STOP and by repeated START
        bus_start();
        cur_req = "R9"; send_byte(8'h6A, 1'b1, 1'b0);
        send_byte(8'h77, 1'b1, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'h6A, 1'b1, 1'b0);
        send_byte(8'h77, 1'b1, 1'b0);
        for (int i = 7; i >= 4; i--) bit_cyc(i[0], 1'b0);
        bus_start();
        send_byte(8'h6A, 1'b1, 1'b0);
        send_byte(8'h99, 1'b1, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'h6A, 1'b1, 1'b0);
        send_byte(8'h01, 1'b1, 1'b0);
        exp_q.push_back(16'h0102);
        send_byte(8'h02, 1'b1, 1'b1);
        bus_stop();

        // R10 R11: full read, controller ACKs both bytes, then extra clocks
        rd_word = 16'hA5C3;
        bus_start();
        cur_req = "R3"; send_byte(8'h6B, 1'b1, 1'b0);
        rd_word = 16'h0000;
        cur_req = "R10 R12"; rd_byte(8'hA5, 1'b1);
        rd_byte(8'hC3, 1'b1);
        cur_req = "R11"; quiet_byte(8'h00);
        bus_stop();

        // R11: NACK after first byte ends the read
        rd_word = 16'h5A0F;
        bus_start();
        cur_req = "R3"; send_byte(8'h6B, 1'b1, 1'b0);
        cur_req = "R10"; rd_byte(8'h5A, 1'b0);
        cur_req = "R11"; quiet_byte(8'h00);
        bus_stop();

        // R2: write, repeated START, read
        rd_word = 16'h3C81;
        bus_start();
        cur_req = "R2"; send_byte(8'h6A, 1'b1, 1'b0);
        send_byte(8'h55, 1'b1, 1'b0);
        bus_start();
        send_byte(8'h6B, 1'b1, 1'b0);
        rd_byte(8'h3C, 1'b1);
        rd_byte(8'h81, 1'b0);
        bus_stop();

        // R4: mismatch at A0 and at A6, then own address pattern without START
        bus_start();
        cur_req = "R4"; send_byte(8'h68, 1'b0, 1'b0);
        quiet_byte(8'h6A);
        bus_stop();
        bus_start();
        send_byte(8'hEA, 1'b0, 1'b0);
        quiet_byte(8'h6A);
        quiet_byte(8'h00);
        bus_stop();

        // R3: address-select pin picks A0
        adr_sel = 1'b0;
        bus_start();
        cur_req = "R3"; send_byte(8'h68, 1'b1, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'h6A, 1'b0, 1'b0);
        bus_stop();
        adr_sel = 1'b1;

        // R7: general call ignored
        bus_start();
        cur_req = "R7"; send_byte(8'h00, 1'b0, 1'b0);
        bus_stop();

        // R6: STOP in the START's own high phase is dropped
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(2);
        cur_req = "R6"; send_byte(8'h6A, 1'b1, 1'b0);
        send_byte(8'h42, 1'b1, 1'b0);
        exp_q.push_back(16'h4224);
        send_byte(8'h24, 1'b1, 1'b1);
        bus_stop();

        // R5: STOP one clock after START is honoured, later bits ignored
        bus_start();
        cur_req = "R5"; bit_cyc(1'b0, 1'b0);
        bus_stop();
        scl_m = 1'b0; tick(2);
        quiet_byte(8'h6A);
        quiet_byte(8'h42);
        scl_m = 1'b1; tick(Q);

        tick(20);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R8: %0d expected commits missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule